// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges the level-sensitive interrupt pins of a group of device slots onto a small set of shared interrupt lines. Every slot has four pins. Each pin is steered to one shared line by a fixed routing rule that rotates with the slot number, so that pin 0 of neighbouring slots lands on different lines and the load is spread.

The block does not OR its inputs together. It keeps the last level seen on every pin and reacts only to changes. A rise adds one to the counter of the line the pin is routed to, and a fall takes one away. A line is driven high while its counter is non-zero, so a line shared by many sources stays asserted until the last of them lets go. Several pins may change in the same cycle, and all of those changes are applied together.

Top module: `irq_line_aggregator`

## Requirements
- R1: Pin `p` (0 to 3) of slot `s` is bit `s*4+p` of `pin_level_i`. Each bit is a level, 0 idle and 1 asserted.
- R2: A pin whose level equals its stored level causes no change to any line counter or output.
- R3: A pin that goes from 0 to 1 adds one to the counter of its routed line, and a pin that goes from 1 to 0 takes one away.
- R4: Line output `line_o[l]` is 1 exactly when the counter of line `l` is non-zero. A shared line stays high until every source routed to it has dropped.
- R5: Pin `p` of slot `s` is routed to line `(p + s) mod 4`.
- R6: While `rst_n` is low at a rising edge, all counters, all stored pin levels and all line outputs are cleared. Pins that are high when reset is released are counted as new rises.
- R7: All pins that change in one cycle are applied in that cycle, so a counter can move by more than one in a single step.
- R8: Each counter can hold every source at once (32 slots times 4 pins) without overflow or underflow.
- R9: The outputs are registered. `line_o` reflects a pin change at the first rising clock edge that samples the new level, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level_i | input | 128 | Interrupt pin levels, bit slot*4+pin |
| line_o | output | 4 | Shared interrupt line outputs |

## Verification
Single pins in distinct slots show that the rotating route sends each pin to the right line. Two sources on one line, dropped one at a time, show that the line follows a count and not the latest edge. Switching every pin on at once and then dropping them in index order tests multi-step counter changes and full occupancy. A reset taken with pins high, and released with them low, shows that stored levels are cleared together with the counters, since stale levels would cause a wrap below zero. A check made just before the clock edge pins down the one-cycle latency.

// File: rtl/irq_agg_pkg.sv
// Package: shared helpers for the interrupt line aggregator.
// Assumes: line index is a pure function of slot and pin numbers.
package irq_agg_pkg;

    // Route a device pin to a shared line: (pin + slot) mod lines.
    function automatic int unsigned route_line(input int unsigned slot,
                                               input int unsigned pin,
                                               input int unsigned lines);
        return (slot + pin) % lines;
    endfunction

endpackage

// File: rtl/irq_pin_tracker.sv
// Module: irq_pin_tracker
// Keeps the last sampled level of every device pin and flags the pins
// that rise or fall in the current cycle.
// Assumes: inputs are synchronous to clk; reset clears stored levels to 0.
module irq_pin_tracker #(
    parameter int unsigned NUM_PINS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] level_i,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);

    logic [NUM_PINS-1:0] level_q;

    // Store the most recent pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_i;
    end

    // Compare against stored levels to find changes.
    always_comb begin
        rise_o = level_i & ~level_q;
        fall_o = ~level_i & level_q;
    end

    // R2: stored level equals the input sampled on the previous edge
    a_r2_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (level_q == $past(level_i)));

endmodule

// File: rtl/irq_line_router.sv
// Module: irq_line_router
// Counts, for each shared line, how many pins routed to it rose and how
// many fell in the current cycle.
// Assumes: pins are grouped PINS_PER_SLOT per slot, slot-major order.
module irq_line_router
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SLOTS     = 32,
    parameter int unsigned PINS_PER_SLOT = 4,
    parameter int unsigned NUM_LINES     = 4,
    parameter int unsigned CNT_W         = 8
) (
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] rise_i,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] fall_i,
    output logic [NUM_LINES-1:0][CNT_W-1:0]    up_o,
    output logic [NUM_LINES-1:0][CNT_W-1:0]    dn_o
);

    localparam int unsigned NUM_PINS = NUM_SLOTS * PINS_PER_SLOT;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        // Build the selection mask of pins routed to this line.
        logic [NUM_PINS-1:0] sel;
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            for (genvar p = 0; p < PINS_PER_SLOT; p++) begin : g_pin
                assign sel[s*PINS_PER_SLOT+p] =
                    (route_line(s, p, NUM_LINES) == l);
            end
        end

        // Tally rises and falls on this line.
        always_comb begin
            up_o[l] = '0;
            dn_o[l] = '0;
            for (int i = 0; i < NUM_PINS; i++) begin
                up_o[l] = up_o[l] + CNT_W'(rise_i[i] & sel[i]);
                dn_o[l] = dn_o[l] + CNT_W'(fall_i[i] & sel[i]);
            end
        end
    end

endmodule

// File: rtl/irq_line_counter.sv
// Module: irq_line_counter
// Holds the number of asserted sources on one shared line and drives the
// registered line output high while that number is non-zero.
// Assumes: falls never exceed stored count plus rises (tracker guarantees).
module irq_line_counter #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned MAX_SRC = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] up_i,
    input  logic [CNT_W-1:0] dn_i,
    output logic             line_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_wide;
    logic [CNT_W-1:0] cnt_d;

    // Apply the signed net change for this cycle.
    always_comb begin
        cnt_wide = {1'b0, cnt_q} + {1'b0, up_i} - {1'b0, dn_i};
        cnt_d    = cnt_wide[CNT_W-1:0];
    end

    // Register the count and the derived line level together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            line_o <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            line_o <= (cnt_d != '0);
        end
    end

    // R8: count never exceeds the number of sources
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_SRC));
    // R4: line level matches count being non-zero
    a_r4_line_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        line_o == (cnt_q != '0));
    // R2: no rises and no falls leave the count unchanged
    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i == '0 && dn_i == '0) |=> $stable(cnt_q));
    // R6: reset clears count and line
    a_r6_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && !line_o));

endmodule

// File: rtl/irq_line_aggregator.sv
// Module: irq_line_aggregator (top)
// Merges four level interrupt pins per slot onto shared lines using
// per-line source counters driven by pin-change events.
// Assumes: synchronous active-low reset; pin levels synchronous to clk.
module irq_line_aggregator #(
    parameter int unsigned NUM_SLOTS     = 32,
    parameter int unsigned PINS_PER_SLOT = 4,
    parameter int unsigned NUM_LINES     = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] pin_level_i,
    output logic [NUM_LINES-1:0]               line_o
);

    localparam int unsigned NUM_PINS = NUM_SLOTS * PINS_PER_SLOT;
    localparam int unsigned CNT_W    = $clog2(NUM_PINS + 1);

    logic [NUM_PINS-1:0]               rise;
    logic [NUM_PINS-1:0]               fall;
    logic [NUM_LINES-1:0][CNT_W-1:0]   up;
    logic [NUM_LINES-1:0][CNT_W-1:0]   dn;

    irq_pin_tracker #(.NUM_PINS(NUM_PINS)) u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pin_level_i),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    irq_line_router #(
        .NUM_SLOTS     (NUM_SLOTS),
        .PINS_PER_SLOT (PINS_PER_SLOT),
        .NUM_LINES     (NUM_LINES),
        .CNT_W         (CNT_W)
    ) u_router (
        .rise_i (rise),
        .fall_i (fall),
        .up_o   (up),
        .dn_o   (dn)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_cnt
        irq_line_counter #(.CNT_W(CNT_W), .MAX_SRC(NUM_PINS)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .up_i   (up[l]),
            .dn_i   (dn[l]),
            .line_o (line_o[l])
        );
    end

    // R3: a pin cannot rise and fall in the same cycle
    a_r3_rise_fall_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (rise & fall) == '0);

endmodule

// File: tb/irq_line_aggregator_tb.sv
`timescale 1ns/1ps
module irq_line_aggregator_tb;

    localparam int NS = 32;
    localparam int NP = 4;
    localparam int NL = 4;
    localparam int NPINS = NS * NP;
    localparam int NVEC = 12;

    // Each entry: {pin levels, expected lines}
    localparam logic [NPINS+NL-1:0] VEC [NVEC] = '{
        {128'h0,        4'b0000},
        {128'h1,        4'b0001},  // slot0 pin0 -> line0
        {128'h81,       4'b0001},  // slot1 pin3 shares line0
        {128'h80,       4'b0001},  // one source left
        {128'h0,        4'b0000},
        {128'h10,       4'b0010},  // slot1 pin0 -> line1
        {128'h88,       4'b1001},  // slot0 pin3 -> 3, slot1 pin3 -> 0
        {128'h40000000_00000000_00000000_00000000, 4'b0010}, // slot31 pin2 -> 1
        {128'h400200,   4'b1000},  // slot2 pin1, slot5 pin2 -> 3
        {{128{1'b1}},   4'b1111},  // all rise together
        {128'h0,        4'b0000},  // all fall together
        {128'h2,        4'b0010}   // slot0 pin1 -> 1
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NPINS-1:0] pins = '0;
    logic [NL-1:0]    line_o;
    int               checks = 0;
    int               errors = 0;
    bit               done = 1'b0;

    always #2.5 clk = ~clk;

    irq_line_aggregator u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_level_i (pins),
        .line_o      (line_o)
    );

    function automatic logic [NL-1:0] model(input logic [NPINS-1:0] v);
        logic [NL-1:0] r = '0;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < NP; p++)
                if (v[s*NP+p]) r[(s+p)%NL] = 1'b1;
        return r;
    endfunction

    task automatic check(input string req, input logic [NL-1:0] exp);
        checks++;
        if (line_o !== exp) begin
            errors++;
            $display("FAIL %s: line_o=%b expected=%b", req, line_o, exp);
        end
    endtask

    task automatic apply(input logic [NPINS-1:0] v);
        @(negedge clk);
        pins = v;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        logic [NPINS-1:0] v;
        // R6: reset state with pins held high
        pins = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R6 reset holds lines low", 4'b0000);
        // R6/R9: pins high at release are counted as rises on first edge
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R6 rises counted after release", 4'b1111);

        apply('0);
        check("R3 all fall", 4'b0000);

        // Table walk: R1 R3 R4 R5 R7
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][NPINS+NL-1:NL]);
            check($sformatf("R5 R4 table entry %0d", i), VEC[i][NL-1:0]);
        end

        // R9: output unchanged before the sampling edge
        apply('0);
        @(negedge clk);
        pins = 128'h1;
        #1;
        check("R9 no change before edge", 4'b0000);
        @(posedge clk);
        #1;
        check("R9 change after edge", 4'b0001);

        // R2: holding levels keeps outputs
        repeat (3) @(posedge clk);
        #1;
        check("R2 steady pin no change", 4'b0001);

        // R8/R7: all on, then drop one pin at a time
        v = '1;
        apply(v);
        check("R8 all sources on", 4'b1111);
        for (int i = 0; i < NPINS; i++) begin
            v[i] = 1'b0;
            apply(v);
            check($sformatf("R8 R4 drop pin %0d", i), model(v));
        end

        // R6: reset with pins high, release with pins low -> no underflow
        apply('1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R6 mid-run reset clears", 4'b0000);
        @(negedge clk);
        pins = '0;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R6 stored levels cleared", 4'b0000);
        apply(128'h20);
        check("R5 slot1 pin1 to line2 after reset", 4'b0100);

        done = 1'b1;
        finish_run();
    end

endmodule